// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block sits between a node that issues an interprocessor interrupt and the N nodes that may receive it. The sender first writes a high command word that carries the destination ID. It then writes a low command word that carries the vector, delivery mode, destination mode, level, trigger and shorthand. The write of the low word is the send. On the next cycle the block presents a one-cycle accept vector with one bit per node, together with the decoded fields of the command.

Each node brings its own configuration: a presence flag, an enable flag, an 8-bit physical ID, an 8-bit logical ID and a flag that selects flat or cluster logical format. Lowest-priority delivery gives the interrupt to exactly one eligible node. That node is chosen by a rotating search that starts just after the node which won the previous lowest-priority send. Every other delivery mode goes to all matching nodes at once.

Top module: `ipi_dest_match`

## Requirements
- R1: After reset, accept_vec and send_valid are 0 and both stored command words read 0.
- R2: A write of the high word stores only bits 31:24, the destination ID. Bits 23:0 of cmd_hi_q read 0.
- R3: A write of the low word stores it with bit 12 (delivery status) forced to 0. send_valid is 1 for exactly the following cycle. The outputs then show vector = bits 7:0, delivery mode = bits 10:8, level = bit 14 and trigger = bit 15.
- R4: Shorthand (bits 19:18) 01 selects only the sender, 10 selects every present node, and 11 selects every present node except the sender. With shorthand 01, 10 or 11 the destination ID is not used.
- R5: With shorthand 00 and bit 11 = 0 (physical), a node matches when the destination ID is 0xFF or equals its physical ID.
- R6: With shorthand 00 and bit 11 = 1, a node in flat format matches when its logical ID AND the destination ID is nonzero.
- R7: With shorthand 00 and bit 11 = 1, a node in cluster format matches when the upper nibbles of its logical ID and the destination ID are equal and the AND of their lower nibbles is nonzero.
- R8: For every delivery mode except 001, all matching present nodes are accepted in the same cycle, whatever their enable flags.
- R9: For delivery mode 001 (lowest priority), exactly one node is accepted. The block scans from the node after the previous winner, wraps around, skips nodes that are absent, unmatched or disabled, and remembers the node it picks as the new winner.
- R10: If no present, enabled, matching node exists for delivery mode 001, accept_vec stays 0 and the remembered winner does not change.
- R11: The remembered winner resets to node N-1, so the first lowest-priority search after reset starts at node 0.
- R12: A node whose presence flag is 0 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_wr | input | 1 | Write strobe for the high command word |
| hi_data | input | 32 | High command word; only bits 31:24 are stored |
| lo_wr | input | 1 | Write strobe for the low command word; starts a send |
| lo_data | input | 32 | Low command word |
| src_node | input | $clog2(NODES) | Index of the node that issues the send |
| node_present | input | NODES | Per-node presence flag |
| node_enable | input | NODES | Per-node enable flag, used only by lowest-priority sends |
| node_phys_id | input | 8*NODES | Physical IDs, node i in bits 8i+7:8i |
| node_log_id | input | 8*NODES | Logical IDs, node i in bits 8i+7:8i |
| node_cluster | input | NODES | 1 = cluster logical format, 0 = flat |
| accept_vec | output | NODES | One-cycle per-node accept pulse |
| send_valid | output | 1 | Marks the cycle in which accept_vec is valid |
| out_vector | output | 8 | Vector of the last stored low word |
| out_dmode | output | 3 | Delivery mode of the last stored low word |
| out_level | output | 1 | Level bit of the last stored low word |
| out_trigger | output | 1 | Trigger bit of the last stored low word |
| cmd_lo_q | output | 32 | Stored low word, bit 12 cleared |
| cmd_hi_q | output | 32 | Stored high word, bits 23:0 cleared |

## Verification
The matcher is driven with every shorthand while the sender sits in different positions and some nodes are absent. These sends show whether the sender is included or excluded and whether presence masks the result. Physical sends use an exact ID, the broadcast value and an ID that matches nobody, which separates equality from broadcast. Logical sends use one-hot flat IDs and cluster IDs that share a lower nibble but differ in the upper one, so a wrong cluster compare shows up. A series of lowest-priority sends with disabled and absent nodes, a wrap past the last node and a send with no eligible node checks the rotation order and that the remembered winner only moves when a node wins.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_DEST   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  localparam logic [2:0] DM_LOWEST  = 3'b001;
  localparam int         STATUS_BIT = 12;
  localparam logic [7:0] PHYS_BCAST = 8'hFF;

  typedef struct packed {
    shorthand_e sh;
    logic       trigger;
    logic       level;
    logic       logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.vector  = w[7:0];
    c.dmode   = w[10:8];
    c.logical = w[11];
    c.level   = w[14];
    c.trigger = w[15];
    c.sh      = shorthand_e'(w[19:18]);
    return c;
  endfunction

  function automatic logic phys_hit(input logic [7:0] dest, input logic [7:0] id);
    return (dest == PHYS_BCAST) || (dest == id);
  endfunction

  function automatic logic flat_hit(input logic [7:0] dest, input logic [7:0] lid);
    return |(dest & lid);
  endfunction

  function automatic logic cluster_hit(input logic [7:0] dest, input logic [7:0] lid);
    return (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
  endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hi_wr,
  input  logic [31:0] hi_data,
  input  logic        lo_wr,
  input  logic [31:0] lo_data,
  output logic [31:0] lo_q,
  output logic [7:0]  dest_q
);
  import ipi_pkg::*;

  localparam logic [31:0] LO_KEEP = ~(32'd1 << STATUS_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      dest_q <= '0;
    end else begin
      if (hi_wr) dest_q <= hi_data[31:24];
      if (lo_wr) lo_q   <= lo_data & LO_KEEP;
    end
  end

  // R3: the stored word never reports a pending send
  a_r3_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> !lo_q[STATUS_BIT]);

  // R2: a high write lands on the stored ID one cycle later
  a_r2_dest_load: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (dest_q == $past(hi_data[31:24])));

endmodule

// File: rtl/ipi_node_match.sv
module ipi_node_match (
  input  ipi_pkg::shorthand_e sh,
  input  logic                logical,
  input  logic [7:0]          dest,
  input  logic                is_src,
  input  logic [7:0]          phys_id,
  input  logic [7:0]          log_id,
  input  logic                cluster,
  output logic                hit
);
  import ipi_pkg::*;

  logic addr_hit;

  always_comb begin
    if (!logical)    addr_hit = phys_hit(dest, phys_id);
    else if (cluster) addr_hit = cluster_hit(dest, log_id);
    else             addr_hit = flat_hit(dest, log_id);
  end

  always_comb begin
    unique case (sh)
      SH_DEST:   hit = addr_hit;
      SH_SELF:   hit = is_src;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_src;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int NODES = 8,
  localparam int IDX_W = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NODES-1:0] req,
  output logic [NODES-1:0] grant,
  output logic             found,
  output logic [IDX_W-1:0] last_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODES - 1);

  logic [IDX_W-1:0] win_idx;

  always_comb begin
    grant   = '0;
    found   = 1'b0;
    win_idx = last_q;
    for (int k = 1; k <= NODES; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NODES;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        win_idx    = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            last_q <= LAST_IDX;
    else if (go && found)  last_q <= win_idx;
  end

  // R10: the remembered winner moves only when a lowest-priority send wins
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && found) |=> $stable(last_q));

  // R9: a granted node was requesting
  a_r9_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ((grant & ~req) == '0));

endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int NODES = 8,
  localparam int IDX_W = $clog2(NODES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hi_wr,
  input  logic [31:0]        hi_data,
  input  logic               lo_wr,
  input  logic [31:0]        lo_data,
  input  logic [IDX_W-1:0]   src_node,
  input  logic [NODES-1:0]   node_present,
  input  logic [NODES-1:0]   node_enable,
  input  logic [8*NODES-1:0] node_phys_id,
  input  logic [8*NODES-1:0] node_log_id,
  input  logic [NODES-1:0]   node_cluster,
  output logic [NODES-1:0]   accept_vec,
  output logic               send_valid,
  output logic [7:0]         out_vector,
  output logic [2:0]         out_dmode,
  output logic               out_level,
  output logic               out_trigger,
  output logic [31:0]        cmd_lo_q,
  output logic [31:0]        cmd_hi_q
);
  import ipi_pkg::*;

  logic [7:0]       dest_q;
  logic [31:0]      lo_q;
  cmd_t             new_cmd;
  cmd_t             held_cmd;
  logic [NODES-1:0] hits;
  logic [NODES-1:0] lp_req;
  logic [NODES-1:0] lp_grant;
  logic             lp_found;
  logic             lp_go;
  logic [IDX_W-1:0] lp_last;
  logic [NODES-1:0] all_accept;

  ipi_cmd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_wr   (hi_wr),
    .hi_data (hi_data),
    .lo_wr   (lo_wr),
    .lo_data (lo_data),
    .lo_q    (lo_q),
    .dest_q  (dest_q)
  );

  assign new_cmd  = decode_cmd(lo_data);
  assign held_cmd = decode_cmd(lo_q);

  for (genvar i = 0; i < NODES; i++) begin : g_node
    ipi_node_match u_match (
      .sh      (new_cmd.sh),
      .logical (new_cmd.logical),
      .dest    (dest_q),
      .is_src  (src_node == IDX_W'(i)),
      .phys_id (node_phys_id[8*i +: 8]),
      .log_id  (node_log_id[8*i +: 8]),
      .cluster (node_cluster[i]),
      .hit     (hits[i])
    );
  end

  assign all_accept = hits & node_present;
  assign lp_req     = all_accept & node_enable;
  assign lp_go      = lo_wr && (new_cmd.dmode == DM_LOWEST);

  ipi_rr_pick #(.NODES(NODES)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (lp_go),
    .req    (lp_req),
    .grant  (lp_grant),
    .found  (lp_found),
    .last_q (lp_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_vec <= '0;
      send_valid <= 1'b0;
    end else begin
      send_valid <= lo_wr;
      if (!lo_wr)     accept_vec <= '0;
      else if (lp_go) accept_vec <= lp_grant;
      else            accept_vec <= all_accept;
    end
  end

  assign out_vector  = held_cmd.vector;
  assign out_dmode   = held_cmd.dmode;
  assign out_level   = held_cmd.level;
  assign out_trigger = held_cmd.trigger;
  assign cmd_lo_q    = lo_q;
  assign cmd_hi_q    = {dest_q, 24'h0};

  // R3: accept pulses only in the cycle after a send
  a_r3_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !send_valid |-> (accept_vec == '0));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr |=> !send_valid);

  // R9: a lowest-priority send reaches at most one node
  a_r9_lowest_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    lp_go |=> $onehot0(accept_vec));

  // R12: absent nodes never accept
  a_r12_absent: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> ((accept_vec & ~$past(node_present)) == '0));

  // R4: the self shorthand reaches the sender alone
  a_r4_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && new_cmd.sh == SH_SELF && new_cmd.dmode != DM_LOWEST) |=>
      (accept_vec == ($past(node_present) & (NODES'(1) << $past(src_node)))));

endmodule

// File: tb/ipi_dest_match_tb.sv
module ipi_dest_match_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             hi_wr, lo_wr;
  logic [31:0]      hi_data, lo_data;
  logic [2:0]       src_node;
  logic [N-1:0]     present, enable, cluster;
  logic [7:0]       phys [N];
  logic [7:0]       lid  [N];
  logic [8*N-1:0]   phys_bus, lid_bus;
  logic [N-1:0]     accept_vec;
  logic             send_valid, out_level, out_trigger;
  logic [7:0]       out_vector;
  logic [2:0]       out_dmode;
  logic [31:0]      cmd_lo_q, cmd_hi_q;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      phys_bus[8*i +: 8] = phys[i];
      lid_bus[8*i +: 8]  = lid[i];
    end
  end

  ipi_dest_match #(.NODES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .hi_data(hi_data),
    .lo_wr(lo_wr), .lo_data(lo_data), .src_node(src_node),
    .node_present(present), .node_enable(enable),
    .node_phys_id(phys_bus), .node_log_id(lid_bus), .node_cluster(cluster),
    .accept_vec(accept_vec), .send_valid(send_valid),
    .out_vector(out_vector), .out_dmode(out_dmode),
    .out_level(out_level), .out_trigger(out_trigger),
    .cmd_lo_q(cmd_lo_q), .cmd_hi_q(cmd_hi_q)
  );

  int n_checks = 0, n_fail = 0;
  int rr_last = N - 1;
  logic [7:0] dest_model = 8'h00;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic node_hits(input int i, input logic [31:0] w);
    logic [1:0] sh;
    sh = w[19:18];
    if (sh == 2'd1) return src_node == 3'(i);
    if (sh == 2'd2) return 1'b1;
    if (sh == 2'd3) return src_node != 3'(i);
    if (w[11] == 1'b0) return dest_model == 8'hFF || dest_model == phys[i];
    if (cluster[i]) return (lid[i] >> 4) == (dest_model >> 4) && (lid[i] & dest_model & 8'h0F) != 0;
    return (lid[i] & dest_model) != 0;
  endfunction

  function automatic logic [N-1:0] expect_accept(input logic [31:0] w);
    logic [N-1:0] r;
    r = '0;
    if (w[10:8] == 3'b001) begin
      for (int k = 1; k <= N; k++) begin
        int j;
        j = (rr_last + k) % N;
        if (r == '0 && present[j] && enable[j] && node_hits(j, w)) r[j] = 1'b1;
      end
    end else begin
      for (int i = 0; i < N; i++) r[i] = present[i] && node_hits(i, w);
    end
    return r;
  endfunction

  task automatic write_hi(input logic [31:0] d);
    hi_wr = 1'b1; hi_data = d;
    @(posedge clk); @(negedge clk);
    hi_wr = 1'b0;
    dest_model = d[31:24];
  endtask

  task automatic send(input logic [31:0] w, input string req);
    logic [N-1:0] exp;
    exp = expect_accept(w);
    lo_wr = 1'b1; lo_data = w;
    @(posedge clk); @(negedge clk);
    lo_wr = 1'b0;
    check(req, {31'd0, send_valid}, 32'd1);
    check(req, {24'd0, accept_vec}, {24'd0, exp});
    if (w[10:8] == 3'b001) begin
      for (int i = 0; i < N; i++) if (exp[i]) rr_last = i;
    end
    @(posedge clk); @(negedge clk);
    check(req, {24'd0, accept_vec}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 accept", {24'd0, accept_vec}, 32'd0);
    check("R1 send_valid", {31'd0, send_valid}, 32'd0);
    check("R1 lo", cmd_lo_q, 32'd0);
    check("R1 hi", cmd_hi_q, 32'd0);
  endtask

  task automatic t_hi_word;
    write_hi(32'hABCDEF12);
    check("R2 hi keep", cmd_hi_q, 32'hAB000000);
  endtask

  task automatic t_fields;
    src_node = 3'd2;
    send(32'hFFFFFFFF, "R3 R4 others");
    check("R3 lo stored", cmd_lo_q, 32'hFFFFEFFF);
    check("R3 vector", {24'd0, out_vector}, 32'hFF);
    check("R3 dmode", {29'd0, out_dmode}, 32'd7);
    check("R3 level", {31'd0, out_level}, 32'd1);
    check("R3 trigger", {31'd0, out_trigger}, 32'd1);
    send(32'h0000_4235, "R3 fixed phys");
    check("R3 vector2", {24'd0, out_vector}, 32'h35);
    check("R3 dmode2", {29'd0, out_dmode}, 32'd2);
    check("R3 level2", {31'd0, out_level}, 32'd1);
    check("R3 trigger2", {31'd0, out_trigger}, 32'd0);
  endtask

  task automatic t_shorthand;
    present = 8'b1101_1111;
    src_node = 3'd4;
    send(32'h0004_0020, "R4 self");
    send(32'h0008_0020, "R4 all R12");
    send(32'h000C_0020, "R4 others R12");
    src_node = 3'd5;
    send(32'h0004_0020, "R4 self absent R12");
    present = '1;
  endtask

  task automatic t_physical;
    write_hi(32'h0600_0000);
    send(32'h0000_0031, "R5 exact");
    write_hi(32'hFF00_0000);
    send(32'h0000_0031, "R5 bcast");
    write_hi(32'h0700_0000);
    send(32'h0000_0031, "R5 none");
  endtask

  task automatic t_flat;
    for (int i = 0; i < N; i++) lid[i] = 8'(1 << i);
    cluster = '0;
    write_hi(32'h0500_0000);
    send(32'h0000_0841, "R6 flat two");
    write_hi(32'h8000_0000);
    send(32'h0000_0841, "R6 flat top");
  endtask

  task automatic t_cluster;
    for (int i = 0; i < N; i++) lid[i] = 8'(((i / 4) << 4) | (1 << (i % 4)));
    cluster = '1;
    write_hi(32'h1300_0000);
    send(32'h0000_0842, "R7 cluster 1");
    write_hi(32'h0300_0000);
    send(32'h0000_0842, "R7 cluster 0");
    write_hi(32'h1000_0000);
    send(32'h0000_0842, "R7 cluster empty");
  endtask

  task automatic t_fixed_enable;
    enable = 8'b0000_0000;
    write_hi(32'hFF00_0000);
    send(32'h0000_0050, "R8 disabled fixed");
    enable = '1;
  endtask

  task automatic t_lowest;
    cluster = '0;
    write_hi(32'hFF00_0000);
    send(32'h0000_0160, "R11 first lowest");
    send(32'h0000_0160, "R9 second lowest");
    enable[2] = 1'b0;
    send(32'h0000_0160, "R9 skip disabled");
    present[4] = 1'b0;
    send(32'h0000_0160, "R9 skip absent");
    write_hi(32'h0200_0000);
    send(32'h0000_0160, "R9 wrap to node1");
    write_hi(32'h0700_0000);
    send(32'h0000_0160, "R10 none eligible");
    enable = '1; present = '1;
    write_hi(32'hFF00_0000);
    send(32'h0000_0160, "R10 pointer held");
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0; hi_data = '0; lo_data = '0;
    src_node = '0; present = '1; enable = '1; cluster = '0;
    for (int i = 0; i < N; i++) begin phys[i] = 8'(2 * i); lid[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hi_word;
    t_fields;
    t_shorthand;
    t_physical;
    t_flat;
    t_cluster;
    t_fixed_enable;
    t_lowest;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule